// File: doc/BRIEF.md
# PLL Output-Divider and Multiplier Search Engine

This block works out the settings for a clock synthesiser that has to produce a requested pixel clock. After a start strobe it multiplies the pixel clock (in kHz) by a clock factor to get the target PLL output frequency, and checks that target against configurable frequency limits. It then steps through the settings of three cascaded power-of-two output dividers. For each candidate it computes the VCO frequency the dividers would need, and it stops at the first candidate whose VCO frequency lies inside the configured VCO window.

From that VCO frequency it derives the feedback multiplier: an integer part M and a fraction scaled to a fixed binary range. The feedback pre-divider N is fixed at 1. All multiplication is done by shift-and-add. All division is done by one shared restoring divider that produces one quotient bit per cycle. One computation takes about a hundred cycles. The limit inputs must stay stable while a computation runs.

Top module: `pll_div_search`

## Requirements
- R1: On start, the target is pclk_khz_i × factor_i. The result is an error if pclk_khz_i > max_pclk_i, if the target < min_pll_i, or if the target > max_pll_i. A value equal to a limit is accepted.
- R2: The divider exponents are visited in this order: e3 counts down from OD_SEL-1 to 0. For each e3, e2 counts down from e3 to 0. For each e2, e1 counts down from e2 to 0. Each divider value is 2^e.
- R3: The candidate VCO frequency is target × 2^(e1+e2+e3). The first candidate with min_vco_i ≤ VCO ≤ max_vco_i ends the search and is reported on vco_o.
- R4: Each divider select output is its divider value shifted right by one: value 1 gives code 0, value 2 gives code 1, value 4 gives code 2.
- R5: n_o is 1 and m_o is floor(VCO / FIN_KHZ).
- R6: frac_o is floor((VCO mod FIN_KHZ) × 2^FRAC_BITS / FIN_KHZ).
- R7: frac_en_o is 1 exactly when frac_o is nonzero.
- R8: If no candidate falls inside the VCO window, the result is an error.
- R9: done_o is a one-cycle pulse. err_o and all result outputs change only in the cycle in which done_o is high, and hold their values until the next done. On an error, every result output reads zero and err_o reads 1.
- R10: A start pulse that arrives while a computation is running is ignored. It produces no extra done, and it does not change the result of the computation in progress.
- R11: After reset, done_o, err_o and every result output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe |
| pclk_khz_i | input | PCLK_W | Requested pixel clock in kHz |
| factor_i | input | FAC_W | Clock multiplication factor |
| max_pclk_i | input | PCLK_W | Highest allowed pixel clock |
| min_pll_i | input | PCLK_W+FAC_W | Lowest allowed target frequency |
| max_pll_i | input | PCLK_W+FAC_W | Highest allowed target frequency |
| min_vco_i | input | VCO_W | Lower edge of the VCO window |
| max_vco_i | input | VCO_W | Upper edge of the VCO window |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Out-of-range or no divider fit |
| od1_sel_o | output | OD_SEL-1 | First divider select code |
| od2_sel_o | output | OD_SEL-1 | Second divider select code |
| od3_sel_o | output | OD_SEL-1 | Third divider select code |
| m_o | output | M_W | Integer feedback multiplier |
| n_o | output | N_W | Feedback pre-divider (always 1) |
| frac_o | output | FRAC_BITS | Fractional feedback multiplier |
| frac_en_o | output | 1 | Fraction is nonzero |
| vco_o | output | VCO_W | Chosen VCO frequency in kHz |

## Verification
A fault in the divider walk shows up as wrong select codes, or as a VCO value that is a different power-of-two multiple of the target. Such a fault is visible at the first done pulse for any request that has several in-range candidates, or several candidates with the same product. A corrupted divider or multiplier register shows up as a wrong M, fraction or VCO at that same done pulse. A fault in the sequencer shows up as a missing done, a second done, or outputs that change between done pulses. The request patterns are chosen to tell these apart: exact and inexact fractions, the deepest and the shallowest candidate, each range limit, and an empty VCO window.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MUL, ST_CHK, ST_SRCH, ST_DIVM, ST_DIVF
  } state_e;
endpackage

// File: rtl/pll_shift_mul.sv
module pll_shift_mul #(
  parameter int A_W = 20,
  parameter int B_W = 8,
  localparam int P_W = A_W + B_W,
  localparam int C_W = $clog2(B_W + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           go_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           done_o,
  output logic [P_W-1:0] prod_o
);
  logic [P_W-1:0] a_q;
  logic [B_W-1:0] b_q;
  logic [C_W-1:0] cnt_q;
  logic           run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; cnt_q <= '0; run_q <= 1'b0;
      prod_o <= '0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        a_q    <= P_W'(a_i);
        b_q    <= b_i;
        prod_o <= '0;
        cnt_q  <= C_W'(B_W);
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (b_q[0]) prod_o <= prod_o + a_q;
        a_q   <= a_q << 1;
        b_q   <= b_q >> 1;
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == C_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_od_walker.sv
module pll_od_walker #(
  parameter int OD_SEL = 3,
  localparam int EXP_W = (OD_SEL > 2) ? $clog2(OD_SEL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  output logic [EXP_W-1:0] e1_o,
  output logic [EXP_W-1:0] e2_o,
  output logic [EXP_W-1:0] e3_o,
  output logic             last_o
);
  localparam logic [EXP_W-1:0] ETOP = EXP_W'(OD_SEL - 1);

  assign last_o = (e1_o == '0) && (e2_o == '0) && (e3_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      e1_o <= '0; e2_o <= '0; e3_o <= '0;
    end else if (load_i) begin
      e1_o <= ETOP; e2_o <= ETOP; e3_o <= ETOP;
    end else if (step_i) begin
      if (e1_o != '0) begin
        e1_o <= e1_o - 1'b1;
      end else if (e2_o != '0) begin
        e2_o <= e2_o - 1'b1;
        e1_o <= e2_o - 1'b1;
      end else if (e3_o != '0) begin
        e3_o <= e3_o - 1'b1;
        e2_o <= e3_o - 1'b1;
        e1_o <= e3_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pll_restore_div.sv
module pll_restore_div #(
  parameter int NUM_W = 34,
  parameter int DVS_W = 15,
  localparam int C_W = $clog2(NUM_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DVS_W-1:0] dvs_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o,
  output logic [DVS_W-1:0] rem_o
);
  logic [C_W-1:0] cnt_q;
  logic           run_q;
  logic [DVS_W:0] trial;
  logic           fits;

  assign trial = {rem_o, quo_o[NUM_W-1]};
  assign fits  = trial >= {1'b0, dvs_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quo_o <= '0; rem_o <= '0; cnt_q <= '0; run_q <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        quo_o <= num_i;
        rem_o <= '0;
        cnt_q <= C_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        // quotient bits shift in where dividend bits shift out
        rem_o <= fits ? DVS_W'(trial - {1'b0, dvs_i}) : trial[DVS_W-1:0];
        quo_o <= {quo_o[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == C_W'(1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int PCLK_W    = 20,
  parameter int FAC_W     = 8,
  parameter int OD_SEL    = 3,
  parameter int FIN_KHZ   = 24000,
  parameter int FRAC_BITS = 17,
  parameter int M_W       = 16,
  parameter int N_W       = 8
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic                                     start_i,
  input  logic [PCLK_W-1:0]                        pclk_khz_i,
  input  logic [FAC_W-1:0]                         factor_i,
  input  logic [PCLK_W-1:0]                        max_pclk_i,
  input  logic [PCLK_W+FAC_W-1:0]                  min_pll_i,
  input  logic [PCLK_W+FAC_W-1:0]                  max_pll_i,
  input  logic [PCLK_W+FAC_W+3*(OD_SEL-1)-1:0]     min_vco_i,
  input  logic [PCLK_W+FAC_W+3*(OD_SEL-1)-1:0]     max_vco_i,
  output logic                                     done_o,
  output logic                                     err_o,
  output logic [OD_SEL-2:0]                        od1_sel_o,
  output logic [OD_SEL-2:0]                        od2_sel_o,
  output logic [OD_SEL-2:0]                        od3_sel_o,
  output logic [M_W-1:0]                           m_o,
  output logic [N_W-1:0]                           n_o,
  output logic [FRAC_BITS-1:0]                     frac_o,
  output logic                                     frac_en_o,
  output logic [PCLK_W+FAC_W+3*(OD_SEL-1)-1:0]     vco_o
);
  import pll_search_pkg::*;

  localparam int TGT_W = PCLK_W + FAC_W;
  localparam int VCO_W = TGT_W + 3 * (OD_SEL - 1);
  localparam int SEL_W = OD_SEL - 1;
  localparam int EXP_W = (OD_SEL > 2) ? $clog2(OD_SEL) : 1;
  localparam int SH_W  = $clog2(3 * (OD_SEL - 1) + 1);
  localparam int FIN_W = $clog2(FIN_KHZ + 1);
  localparam int DIV_W = (VCO_W > FIN_W + FRAC_BITS) ? VCO_W : FIN_W + FRAC_BITS;

  state_e               state_q;
  logic [PCLK_W-1:0]    pclk_q;
  logic [TGT_W-1:0]     tgt_q;
  logic [VCO_W-1:0]     vco_q;
  logic [M_W-1:0]       m_q;
  logic [SEL_W-1:0]     s1_q, s2_q, s3_q;
  logic                 mul_go, mul_done;
  logic [TGT_W-1:0]     mul_prod;
  logic                 div_go, div_done;
  logic [DIV_W-1:0]     div_num, div_quo;
  logic [FIN_W-1:0]     div_rem;
  logic [EXP_W-1:0]     e1, e2, e3;
  logic                 walk_last, walk_load, walk_step;
  logic [SH_W-1:0]      shamt;
  logic [VCO_W-1:0]     cand;
  logic                 hit, range_bad;

  function automatic logic [SEL_W-1:0] sel_code(input logic [EXP_W-1:0] e);
    logic [SEL_W:0] v;
    v = {{SEL_W{1'b0}}, 1'b1} << e;
    return v[SEL_W:1];
  endfunction

  assign shamt     = SH_W'(e1) + SH_W'(e2) + SH_W'(e3);
  assign cand      = VCO_W'(tgt_q) << shamt;
  assign hit       = (cand >= min_vco_i) && (cand <= max_vco_i);
  assign range_bad = (pclk_q > max_pclk_i) || (tgt_q < min_pll_i) || (tgt_q > max_pll_i);
  assign walk_load = (state_q == ST_CHK) && !range_bad;
  assign walk_step = (state_q == ST_SRCH) && !hit;

  pll_shift_mul #(.A_W(PCLK_W), .B_W(FAC_W)) u_mul (
    .clk_i, .rst_ni, .go_i(mul_go), .a_i(pclk_khz_i), .b_i(factor_i),
    .done_o(mul_done), .prod_o(mul_prod)
  );

  pll_od_walker #(.OD_SEL(OD_SEL)) u_walk (
    .clk_i, .rst_ni, .load_i(walk_load), .step_i(walk_step),
    .e1_o(e1), .e2_o(e2), .e3_o(e3), .last_o(walk_last)
  );

  pll_restore_div #(.NUM_W(DIV_W), .DVS_W(FIN_W)) u_div (
    .clk_i, .rst_ni, .go_i(div_go), .num_i(div_num), .dvs_i(FIN_W'(FIN_KHZ)),
    .done_o(div_done), .quo_o(div_quo), .rem_o(div_rem)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pclk_q <= '0; tgt_q <= '0; vco_q <= '0; m_q <= '0;
      s1_q <= '0; s2_q <= '0; s3_q <= '0;
      mul_go <= 1'b0; div_go <= 1'b0; div_num <= '0;
      done_o <= 1'b0; err_o <= 1'b0;
      od1_sel_o <= '0; od2_sel_o <= '0; od3_sel_o <= '0;
      m_o <= '0; n_o <= '0; frac_o <= '0; frac_en_o <= 1'b0; vco_o <= '0;
    end else begin
      mul_go <= 1'b0;
      div_go <= 1'b0;
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pclk_q  <= pclk_khz_i;
          mul_go  <= 1'b1;
          state_q <= ST_MUL;
        end
        ST_MUL: if (mul_done) begin
          tgt_q   <= mul_prod;
          state_q <= ST_CHK;
        end
        ST_CHK: state_q <= range_bad ? ST_IDLE : ST_SRCH;
        ST_SRCH: begin
          if (hit) begin
            vco_q   <= cand;
            s1_q    <= sel_code(e1);
            s2_q    <= sel_code(e2);
            s3_q    <= sel_code(e3);
            div_num <= DIV_W'(cand);
            div_go  <= 1'b1;
            state_q <= ST_DIVM;
          end else if (walk_last) begin
            state_q <= ST_IDLE;
          end
        end
        ST_DIVM: if (div_done) begin
          m_q     <= div_quo[M_W-1:0];
          div_num <= DIV_W'(div_rem) << FRAC_BITS;
          div_go  <= 1'b1;
          state_q <= ST_DIVF;
        end
        ST_DIVF: if (div_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase

      // result publication
      if ((state_q == ST_CHK && range_bad) ||
          (state_q == ST_SRCH && !hit && walk_last)) begin
        done_o <= 1'b1; err_o <= 1'b1;
        od1_sel_o <= '0; od2_sel_o <= '0; od3_sel_o <= '0;
        m_o <= '0; n_o <= '0; frac_o <= '0; frac_en_o <= 1'b0; vco_o <= '0;
      end else if (state_q == ST_DIVF && div_done) begin
        done_o    <= 1'b1;
        err_o     <= 1'b0;
        od1_sel_o <= s1_q; od2_sel_o <= s2_q; od3_sel_o <= s3_q;
        m_o       <= m_q;
        n_o       <= N_W'(1);
        frac_o    <= div_quo[FRAC_BITS-1:0];
        frac_en_o <= |div_quo[FRAC_BITS-1:0];
        vco_o     <= vco_q;
      end
    end
  end
endmodule

// File: rtl/pll_div_search_chk.sv
module pll_div_search_chk #(
  parameter int VCO_W   = 34,
  parameter int SEL_W   = 2,
  parameter int M_W     = 16,
  parameter int N_W     = 8,
  parameter int FIN_KHZ = 24000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             done_o,
  input logic             err_o,
  input logic [SEL_W-1:0] od1_sel_o,
  input logic [SEL_W-1:0] od2_sel_o,
  input logic [SEL_W-1:0] od3_sel_o,
  input logic [M_W-1:0]   m_o,
  input logic [N_W-1:0]   n_o,
  input logic [VCO_W-1:0] vco_o,
  input logic [VCO_W-1:0] min_vco_i,
  input logic [VCO_W-1:0] max_vco_i
);
  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(vco_o) && $stable(m_o) && $stable(err_o) && $stable(od1_sel_o)));

  assert_err_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && err_o) |-> (vco_o == '0 && m_o == '0 && n_o == '0));

  assert_vco_window_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (vco_o >= min_vco_i && vco_o <= max_vco_i));

  assert_sel_pow2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($onehot0(od1_sel_o) && $onehot0(od2_sel_o) && $onehot0(od3_sel_o)));

  assert_m_bracket_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !err_o) |-> (n_o == N_W'(1) &&
      64'(m_o) * 64'(FIN_KHZ) <= 64'(vco_o) &&
      64'(vco_o) < (64'(m_o) + 64'd1) * 64'(FIN_KHZ)));
endmodule

bind pll_div_search pll_div_search_chk #(
  .VCO_W(VCO_W), .SEL_W(SEL_W), .M_W(M_W), .N_W(N_W), .FIN_KHZ(FIN_KHZ)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .done_o(done_o), .err_o(err_o),
  .od1_sel_o(od1_sel_o), .od2_sel_o(od2_sel_o), .od3_sel_o(od3_sel_o),
  .m_o(m_o), .n_o(n_o), .vco_o(vco_o), .min_vco_i(min_vco_i), .max_vco_i(max_vco_i)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
  localparam int PCLK_W = 20, FAC_W = 8, OD_SEL = 3, FIN = 24000, FRAC_BITS = 17;
  localparam int TGT_W = PCLK_W + FAC_W;
  localparam int VCO_W = TGT_W + 3 * (OD_SEL - 1);

  typedef struct {
    bit      err;
    longint  vco, m, n, frac;
    longint  s1, s2, s3;
    bit      fe;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [PCLK_W-1:0] pclk = '0, max_pclk = '0;
  logic [FAC_W-1:0]  fac = '0;
  logic [TGT_W-1:0]  min_pll = '0, max_pll = '0;
  logic [VCO_W-1:0]  min_vco = '0, max_vco = '0;
  logic done, err, fe;
  logic [OD_SEL-2:0] s1, s2, s3;
  logic [15:0] m;
  logic [7:0]  n;
  logic [FRAC_BITS-1:0] frac;
  logic [VCO_W-1:0] vco;

  int checks = 0, errors = 0, cyc = 0;
  exp_t sb[$];

  always #4 clk = ~clk;

  pll_div_search u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pclk_khz_i(pclk), .factor_i(fac),
    .max_pclk_i(max_pclk), .min_pll_i(min_pll), .max_pll_i(max_pll),
    .min_vco_i(min_vco), .max_vco_i(max_vco), .done_o(done), .err_o(err),
    .od1_sel_o(s1), .od2_sel_o(s2), .od3_sel_o(s3), .m_o(m), .n_o(n),
    .frac_o(frac), .frac_en_o(fe), .vco_o(vco)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input longint p, input longint f);
    exp_t r;
    longint t, v;
    r = '{err: 1'b1, vco: 0, m: 0, n: 0, frac: 0, s1: 0, s2: 0, s3: 0, fe: 1'b0};
    t = p * f;
    if (p > max_pclk || t < min_pll || t > max_pll) return r;
    for (int o3 = 1 << (OD_SEL - 1); o3 > 0; o3 >>= 1)
      for (int o2 = o3; o2 > 0; o2 >>= 1)
        for (int o1 = o2; o1 > 0; o1 >>= 1) begin
          v = t * o3 * o2 * o1;
          if (v >= longint'(min_vco) && v <= longint'(max_vco)) begin
            r.err = 1'b0; r.vco = v; r.n = 1; r.m = v / FIN;
            r.frac = ((v % FIN) * (longint'(1) << FRAC_BITS)) / FIN;
            r.fe = (r.frac != 0);
            r.s1 = o1 >> 1; r.s2 = o2 >> 1; r.s3 = o3 >> 1;
            return r;
          end
        end
    return r;
  endfunction

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk("R10 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk("R1/R8 err", err, e.err);
        chk("R3 vco", vco, e.vco);
        chk("R4 od1", s1, e.s1);
        chk("R4 od2", s2, e.s2);
        chk("R2 od3", s3, e.s3);
        chk("R5 m", m, e.m);
        chk("R5 n", n, e.n);
        chk("R6 frac", frac, e.frac);
        chk("R7 frac_en", fe, e.fe);
      end
    end
  end

  task automatic run(input longint p, input longint f, input bit extra_start);
    @(negedge clk);
    pclk = PCLK_W'(p); fac = FAC_W'(f);
    sb.push_back(model(p, f));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (extra_start) begin
      // R10: second start with different inputs mid-run
      repeat (5) @(negedge clk);
      pclk = PCLK_W'(p + 1000); fac = FAC_W'(f + 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic limits(input longint vlo, input longint vhi);
    max_pclk = PCLK_W'(200000); min_pll = TGT_W'(100000); max_pll = TGT_W'(3000000);
    min_vco = VCO_W'(vlo); max_vco = VCO_W'(vhi);
  endtask

  initial begin
    longint held;
    limits(3000000, 6000000);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 done", done, 0); chk("R11 err", err, 0); chk("R11 vco", vco, 0);
    chk("R11 m", m, 0); chk("R11 n", n, 0); chk("R11 frac", frac, 0);
    rst_n = 1'b1;

    run(67000, 8, 0);        // R6 R7 inexact fraction, R2 equal-product order
    held = longint'(vco);
    repeat (20) @(negedge clk);
    chk("R9 vco held", vco, held);
    chk("R9 done low", done, 0);
    run(75000, 8, 0);        // R7 exact fraction
    run(200000, 4, 0);       // R1 pclk at limit accepted
    run(250000, 4, 0);       // R1 pclk over limit
    run(10000, 5, 0);        // R1 target under min
    run(199000, 16, 0);      // R1 target over max
    run(20000, 5, 0);        // R1 target equals min
    limits(3000000, 5900000);
    run(187500, 16, 0);      // R2 deepest candidate, all codes zero
    limits(3000000, 6000000);
    run(187500, 16, 0);      // R3 upper window edge inclusive
    limits(4000000, 4100000);
    run(75000, 8, 0);        // R8 no candidate fits
    chk("R9 err zeroes m", m, 0);
    limits(3000000, 6000000);
    run(120000, 7, 1);       // R10 start ignored while busy
    repeat (150) @(negedge clk);
    chk("R10 no pending", sb.size(), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule